// File: doc/BRIEF.md
# Wide-Bus to Narrow-Memory Byte Assembler

This block sits between a processor bus with a 64-bit data path and a memory that is only 32, 16 or 8 bits wide. The processor presents one request: a quadword address, eight active-low byte enables, and write data for a write. The block works out which narrow-memory chunks of that quadword hold at least one enabled byte. It then runs one narrow access per such chunk, in ascending address order. For each access it generates the memory's low address bits and its local byte enables, and moves every byte between its processor lane and the matching memory lane.

On reads, the bytes from each narrow access are collected into a 64-bit holding register. The processor receives one ready pulse only after the last byte has arrived, so the whole operand comes back in a single transfer. On writes, that same single ready pulse follows completion of the last narrow write. The memory width is chosen per request by a two-bit code, so one instance can serve memories of different widths behind an address decoder.

Top module: `nb_narrow_bridge`

## Requirements
- R1: While reset is held, mem_req and cpu_rdy are low and cpu_rdata is zero.
- R2: cpu_width is sampled when a request is accepted. The codes are: 2'b00 selects an 8-bit memory, 2'b01 a 16-bit memory, 2'b10 a 32-bit memory, and 2'b11 behaves exactly like 2'b10.
- R3: Split the quadword into chunks of the memory width, numbered from byte 0 upward. Exactly one narrow access is issued per chunk that has an enabled byte, lowest chunk first. mem_addr is the request's quadword address followed by the chunk's byte offset: 3 low bits of value chunk x width in bytes.
- R4: mem_be_n is active low. Lane j is low exactly when processor byte (chunk offset + j) is enabled. Lanes at or above the memory width are held high, so a 16-bit memory uses lane 1 as its high byte and lane 0 as its low byte.
- R5: On writes, mem_wdata lane j carries processor byte (chunk offset + j). Lanes at or above the memory width are zero.
- R6: On reads, each enabled processor byte is taken from its memory lane during the access that covers it. Bytes that are not enabled are returned as zero.
- R7: Once raised, mem_req stays high with mem_addr, mem_be_n, mem_we and mem_wdata stable until the cycle in which mem_ack is sampled high.
- R8: cpu_rdy is a one-cycle pulse in the cycle after the last narrow access is acknowledged, for both reads and writes. It is never high while a narrow access is pending. cpu_rdata is valid with it.
- R9: A request with all eight byte enables high runs no narrow access. cpu_rdy pulses in the cycle after the request, with cpu_rdata zero.
- R10: A cpu_req raised while narrow accesses are still outstanding, including the cycle of the final acknowledge, is ignored. A cpu_req in the cycle cpu_rdy is high is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Request strobe, taken when the block is idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W-3 | Quadword address (byte address bits 31:3) |
| cpu_be_n | input | 8 | Active-low byte enables, bit i = byte lane i |
| cpu_wdata | input | 64 | Write data, byte i on bits 8i+7:8i |
| cpu_width | input | 2 | Memory width code (see R2) |
| cpu_rdy | output | 1 | Single completion pulse |
| cpu_rdata | output | 64 | Assembled read data |
| mem_req | output | 1 | Narrow access request |
| mem_we | output | 1 | Narrow access direction |
| mem_addr | output | ADDR_W | Narrow byte address including generated low bits |
| mem_be_n | output | 4 | Active-low local byte enables |
| mem_wdata | output | 32 | Steered write data |
| mem_rdata | input | 32 | Narrow read data |
| mem_ack | input | 1 | Narrow access completion |

## Verification
The case that needs care is the completion of one request falling in the same cycle as the start of the next. The cpu_rdy pulse of a finishing request coincides with the acceptance of a new cpu_req. Separately, the final mem_ack coincides with a cpu_req that must be dropped. The bench issues most requests with no idle gap, so each new request is raised in the ready cycle of the previous one. On some requests it also injects a stray request, with a different address and full enables, while accesses are still pending. A behavioural model predicts the narrow accesses, the ready cycle and the gathered data on every clock. A wrongly taken or wrongly dropped request therefore shows up directly as an address, enable or ready mismatch.

// File: rtl/nb_pkg.sv
// Package: shared width codes and helpers for the narrow-memory bridge.
// Assumes the processor bus is 8 bytes wide and the widest memory is 4 bytes.
package nb_pkg;

    typedef enum logic [1:0] {
        NW_BYTE  = 2'b00,
        NW_HALF  = 2'b01,
        NW_WORD  = 2'b10,
        NW_WORD2 = 2'b11
    } nw_width_e;

    // Map a width code onto log2 of the memory width in bytes.
    function automatic logic [1:0] nw_shift(input logic [1:0] code);
        return (code == NW_WORD2) ? 2'd2 : code;
    endfunction

endpackage

// File: rtl/nb_chunk_plan.sv
// nb_chunk_plan: from the active-low byte enables and the width shift,
// marks every memory-width chunk that holds at least one enabled byte.
// Assumes chunk k covers bytes k<<shift .. ((k+1)<<shift)-1.
module nb_chunk_plan #(
    parameter int BUS_BYTES = 8,
    localparam int IW = $clog2(BUS_BYTES)
) (
    input  logic [BUS_BYTES-1:0] be_n,
    input  logic [1:0]           shift,
    output logic [BUS_BYTES-1:0] chunk_mask
);

    // Fold each enabled byte onto the chunk that contains it.
    always_comb begin
        chunk_mask = '0;
        for (int b = 0; b < BUS_BYTES; b++) begin
            if (!be_n[b]) begin
                chunk_mask[IW'(b) >> shift] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/nb_first_set.sv
// nb_first_set: priority encoder returning the lowest set bit of a vector.
// Assumes nothing about the vector; idx is zero when no bit is set.
module nb_first_set #(
    parameter int N = 8,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          any
);

    // Scan downward so the lowest set bit wins.
    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IW'(i);
                any = 1'b1;
            end
        end
    end

endmodule

// File: rtl/nb_lane_steer.sv
// nb_lane_steer: for the current chunk, forms the byte offset, the local
// active-low byte enables and the write data. It also places read bytes
// back onto their processor lanes. Lanes beyond the memory width are idle.
// Assumes MEM_BYTES << 0 .. max shift never runs past BUS_BYTES.
module nb_lane_steer #(
    parameter int BUS_BYTES = 8,
    parameter int MEM_BYTES = 4,
    localparam int IW = $clog2(BUS_BYTES)
) (
    input  logic [1:0]             shift,
    input  logic [IW-1:0]          idx,
    input  logic [BUS_BYTES-1:0]   en,
    input  logic [8*BUS_BYTES-1:0] wdata,
    input  logic [8*MEM_BYTES-1:0] rdata,
    output logic [IW-1:0]          offset,
    output logic [MEM_BYTES-1:0]   lane_be_n,
    output logic [8*MEM_BYTES-1:0] lane_wdata,
    output logic [8*BUS_BYTES-1:0] gather_data
);

    // Byte offset of the chunk inside the quadword.
    always_comb offset = idx << shift;

    // Route each used memory lane to and from its processor lane.
    always_comb begin
        lane_be_n   = '1;
        lane_wdata  = '0;
        gather_data = '0;
        for (int j = 0; j < MEM_BYTES; j++) begin
            if (j < (1 << shift)) begin
                lane_be_n[j] = ~en[offset + IW'(j)];
                lane_wdata[8*j +: 8] = wdata[8*(offset + IW'(j)) +: 8];
                if (en[offset + IW'(j)]) begin
                    gather_data[8*(offset + IW'(j)) +: 8] = rdata[8*j +: 8];
                end
            end
        end
    end

endmodule

// File: rtl/nb_narrow_bridge.sv
// nb_narrow_bridge: accepts one 64-bit processor request, issues one
// narrow access per chunk with enabled bytes (ascending), gathers read
// bytes and returns a single cpu_rdy pulse when all are done.
// Assumes mem_ack is only meaningful while mem_req is high.
module nb_narrow_bridge #(
    parameter int ADDR_W    = 32,
    parameter int BUS_BYTES = 8,
    parameter int MEM_BYTES = 4,
    localparam int IW = $clog2(BUS_BYTES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cpu_req,
    input  logic                   cpu_we,
    input  logic [ADDR_W-1:IW]     cpu_addr,
    input  logic [BUS_BYTES-1:0]   cpu_be_n,
    input  logic [8*BUS_BYTES-1:0] cpu_wdata,
    input  logic [1:0]             cpu_width,
    output logic                   cpu_rdy,
    output logic [8*BUS_BYTES-1:0] cpu_rdata,
    output logic                   mem_req,
    output logic                   mem_we,
    output logic [ADDR_W-1:0]      mem_addr,
    output logic [MEM_BYTES-1:0]   mem_be_n,
    output logic [8*MEM_BYTES-1:0] mem_wdata,
    input  logic [8*MEM_BYTES-1:0] mem_rdata,
    input  logic                   mem_ack
);
    import nb_pkg::*;

    logic                   busy_q;
    logic                   we_q;
    logic                   rdy_q;
    logic [1:0]             shift_q;
    logic [ADDR_W-1:IW]     addr_q;
    logic [BUS_BYTES-1:0]   en_q;
    logic [BUS_BYTES-1:0]   pend_q;
    logic [8*BUS_BYTES-1:0] wdata_q;
    logic [8*BUS_BYTES-1:0] data_q;

    logic [BUS_BYTES-1:0]   req_mask;
    logic [IW-1:0]          cur_idx;
    logic                   pend_any;
    logic [IW-1:0]          cur_off;
    logic [8*BUS_BYTES-1:0] gather;
    logic [BUS_BYTES-1:0]   pend_next;
    logic                   step;

    nb_chunk_plan #(.BUS_BYTES(BUS_BYTES)) u_plan (
        .be_n       (cpu_be_n),
        .shift      (nw_shift(cpu_width)),
        .chunk_mask (req_mask)
    );

    nb_first_set #(.N(BUS_BYTES)) u_pick (
        .vec (pend_q),
        .idx (cur_idx),
        .any (pend_any)
    );

    nb_lane_steer #(.BUS_BYTES(BUS_BYTES), .MEM_BYTES(MEM_BYTES)) u_steer (
        .shift       (shift_q),
        .idx         (cur_idx),
        .en          (en_q),
        .wdata       (wdata_q),
        .rdata       (mem_rdata),
        .offset      (cur_off),
        .lane_be_n   (mem_be_n),
        .lane_wdata  (mem_wdata),
        .gather_data (gather)
    );

    // Narrow-side outputs come straight from the held request.
    always_comb begin
        mem_req  = busy_q && pend_any;
        mem_we   = we_q;
        mem_addr = {addr_q, cur_off};
        step     = mem_req && mem_ack;
        pend_next = pend_q & ~(BUS_BYTES'(1) << cur_idx);
    end

    // Request capture, chunk retirement, read gathering and ready pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            we_q    <= 1'b0;
            rdy_q   <= 1'b0;
            shift_q <= '0;
            addr_q  <= '0;
            en_q    <= '0;
            pend_q  <= '0;
            wdata_q <= '0;
            data_q  <= '0;
        end else begin
            rdy_q <= 1'b0;
            if (!busy_q && cpu_req) begin
                we_q    <= cpu_we;
                shift_q <= nw_shift(cpu_width);
                addr_q  <= cpu_addr;
                en_q    <= ~cpu_be_n;
                pend_q  <= req_mask;
                wdata_q <= cpu_wdata;
                data_q  <= '0;
                if (req_mask == '0) begin
                    rdy_q <= 1'b1;
                end else begin
                    busy_q <= 1'b1;
                end
            end else if (step) begin
                pend_q <= pend_next;
                if (!we_q) begin
                    data_q <= data_q | gather;
                end
                if (pend_next == '0) begin
                    busy_q <= 1'b0;
                    rdy_q  <= 1'b1;
                end
            end
        end
    end

    assign cpu_rdy   = rdy_q;
    assign cpu_rdata = data_q;

endmodule

// File: rtl/nb_narrow_bridge_chk.sv
// nb_narrow_bridge_chk: port-level protocol checks, bound to the bridge.
// Assumes the bridge's port names and default bus widths.
module nb_narrow_bridge_chk #(
    parameter int ADDR_W    = 32,
    parameter int MEM_BYTES = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cpu_rdy,
    input logic                   mem_req,
    input logic                   mem_we,
    input logic [ADDR_W-1:0]      mem_addr,
    input logic [MEM_BYTES-1:0]   mem_be_n,
    input logic [8*MEM_BYTES-1:0] mem_wdata,
    input logic                   mem_ack
);

    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_be_n)
                                 && $stable(mem_we) && $stable(mem_wdata)); // R7

    AST_ADDR_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack |=> !mem_req || (mem_addr > $past(mem_addr))); // R3

    AST_BE_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_be_n != '1)); // R3

    AST_RDY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rdy |-> !mem_req); // R8

endmodule

bind nb_narrow_bridge nb_narrow_bridge_chk #(.ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_rdy   (cpu_rdy),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_be_n  (mem_be_n),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack)
);

// File: tb/nb_narrow_bridge_tb.sv
module nb_narrow_bridge_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NTX  = 14;
    localparam int WDOG = 5000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_req, cpu_we, cpu_rdy;
    logic [31:3] cpu_addr;
    logic [7:0]  cpu_be_n;
    logic [63:0] cpu_wdata, cpu_rdata;
    logic [1:0]  cpu_width;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  mem_be_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    nb_narrow_bridge u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_be_n(cpu_be_n), .cpu_wdata(cpu_wdata),
        .cpu_width(cpu_width), .cpu_rdy(cpu_rdy), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_be_n(mem_be_n), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack)
    );

    // Memory contents: a fixed function of the byte address.
    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    always_comb begin
        for (int j = 0; j < 4; j++) mem_rdata[8*j +: 8] = mem_byte(mem_addr + 32'(j));
    end

    typedef struct {
        logic [31:0] addr;
        logic [3:0]  be_n;
        logic [31:0] wdata;
        logic        we;
    } acc_t;

    acc_t        q[$];
    int          checks = 0, errors = 0;
    logic        m_busy = 1'b0, exp_rdy = 1'b0, last_we = 1'b0;
    logic [63:0] exp_data = '0;

    logic [1:0]  t_w[NTX];
    logic        t_we[NTX];
    logic [7:0]  t_be[NTX];
    logic        t_spur[NTX];
    int          t_gap[NTX];
    string       t_tag[NTX];
    int          ti = 0;

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s txn %0d (%s) at %0t: actual %h expected %h",
                     rq, ti, (ti > 0) ? t_tag[ti-1] : "reset", $time, act, exp);
        end
    endtask

    // Expected narrow accesses for one request, from R2..R5.
    task automatic plan(input logic [1:0] w, input logic we, input logic [31:3] a,
                        input logic [7:0] be_n, input logic [63:0] wd);
        int s, wb;
        s  = (w == 2'b11) ? 2 : int'(w);
        wb = 1 << s;
        for (int k = 0; k < (8 >> s); k++) begin
            acc_t e;
            bit   hit = 0;
            e.addr = {a, 3'(k * wb)};
            e.be_n = 4'hF;
            e.wdata = '0;
            e.we = we;
            for (int j = 0; j < wb; j++) begin
                e.be_n[j] = be_n[k*wb + j];
                e.wdata[8*j +: 8] = wd[8*(k*wb + j) +: 8];
                if (!be_n[k*wb + j]) hit = 1;
            end
            if (hit) q.push_back(e);
        end
    endtask

    initial begin
        int cyc = 0, gap_cnt = 0, ack_wait = 0, nacks = 0;
        bit spur_done = 0, accept, nrdy, fin = 0;
        t_w = '{2'd2,2'd2,2'd1,2'd0,2'd0,2'd1,2'd3,2'd2,2'd0,2'd1,2'd0,2'd2,2'd1,2'd0};
        t_we = '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1};
        t_be = '{8'h00,8'hF0,8'hE7,8'h00,8'hC3,8'h7F,8'h3F,8'hFF,8'hFF,8'h00,8'hFE,8'h0F,8'hF8,8'hE1};
        t_spur = '{0,0,0,1,0,0,0,0,0,1,0,1,0,0};
        t_gap = '{0,2,0,1,0,0,3,0,0,1,0,0,2,0};
        t_tag = '{"R6","R3","R4","R5","R6","R4","R2","R9","R9","R10","R10","R5","R3","R5"};

        cpu_req = 0; cpu_we = 0; cpu_addr = '0; cpu_be_n = '1; cpu_wdata = '0;
        cpu_width = '0; mem_ack = 0; rst_n = 0;
        repeat (3) @(negedge clk);
        chk(mem_req == 1'b0, "R1", 64'(mem_req), 64'd0);
        chk(cpu_rdy == 1'b0, "R1", 64'(cpu_rdy), 64'd0);
        chk(cpu_rdata == '0, "R1", cpu_rdata, 64'd0);
        rst_n = 1;

        while (!fin && cyc < WDOG) begin
            @(negedge clk);
            cyc++;
            // Compare outputs with the model.
            chk(mem_req == (q.size() != 0), "R3", 64'(mem_req), 64'(q.size() != 0));
            if (q.size() != 0 && mem_req) begin
                chk(mem_addr == q[0].addr, "R3", 64'(mem_addr), 64'(q[0].addr));
                chk(mem_be_n == q[0].be_n, "R4", 64'(mem_be_n), 64'(q[0].be_n));
                chk(mem_we == q[0].we, "R7", 64'(mem_we), 64'(q[0].we));
                if (q[0].we) chk(mem_wdata == q[0].wdata, "R5", 64'(mem_wdata), 64'(q[0].wdata));
            end
            chk(cpu_rdy == exp_rdy, "R8", 64'(cpu_rdy), 64'(exp_rdy));
            if (exp_rdy && cpu_rdy && !last_we) chk(cpu_rdata == exp_data, "R6", cpu_rdata, exp_data);
            if (ti == NTX && !m_busy && !exp_rdy) fin = 1;

            // Drive inputs for the coming edge.
            mem_ack = 0; cpu_req = 0; accept = 0;
            if (q.size() != 0 && mem_req) begin
                if (ack_wait == 0) begin
                    mem_ack = 1; nacks++; ack_wait = (nacks * 7) % 3;
                end else ack_wait--;
            end
            if (!m_busy) begin
                if (ti < NTX) begin
                    if (gap_cnt >= t_gap[ti]) begin
                        cpu_req = 1; cpu_we = t_we[ti]; cpu_width = t_w[ti];
                        cpu_be_n = t_be[ti];
                        cpu_addr = 29'(ti * 37 + 29'h1000);
                        cpu_wdata = {32'(ti) * 32'h01030507, 32'h8899AABB ^ 32'(ti)};
                        accept = 1; gap_cnt = 0; spur_done = 0; ti++;
                    end else gap_cnt++;
                end
            end else if (ti > 0 && t_spur[ti-1] && !spur_done && q.size() >= 2) begin
                // R10: stray request while busy must be ignored.
                cpu_req = 1; cpu_we = ~cpu_we; cpu_be_n = 8'h00; cpu_width = 2'b00;
                cpu_addr = ~cpu_addr; spur_done = 1;
            end

            // Advance the model across the coming edge.
            nrdy = 0;
            if (mem_ack && q.size() != 0) begin
                acc_t e;
                e = q.pop_front();
                if (!e.we) begin
                    for (int j = 0; j < 4; j++)
                        if (!e.be_n[j]) exp_data[8*(int'(e.addr[2:0]) + j) +: 8] = mem_byte(e.addr + 32'(j));
                end
                if (q.size() == 0) begin nrdy = 1; m_busy = 0; end
            end
            if (accept) begin
                exp_data = '0; last_we = cpu_we;
                plan(cpu_width, cpu_we, cpu_addr, cpu_be_n, cpu_wdata);
                if (q.size() == 0) nrdy = 1; else m_busy = 1;
            end
            exp_rdy = nrdy;
        end
        if (!fin) begin
            checks++; errors++;
            $display("FAIL R8 watchdog: actual no completion after %0d cycles, expected completion", cyc);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule